// File: doc/BRIEF.md
# Attack/Decay Triangle Envelope Generator

This block produces an 8-bit envelope code for an external digital-to-analog converter. A bidirectional level counter climbs from 0 to 255 at a programmable attack rate. It then descends from 255 to 0 at a separately programmable decay rate and climbs again. The result is a continuous rise-and-fall ramp whose two slopes are set independently.

Each slope is paced by its own tick generator. A generator emits a one-cycle step enable every (divisor + 1) clocks. Only the generator that matches the present direction is allowed to run. The direction flips at each extreme of the count, so the value never wraps between 0 and 255.

A raw pushbutton input is synchronized and debounced on chip. Each accepted press toggles a freeze. While frozen, the level and the direction stay where they are. A later press lets the ramp carry on from the held value, with no reload.

Top module: `envelope_ramp_gen`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the level is 0, `falling` is 0 (rising) and `frozen` is 0.
- R2: While rising and not frozen, the level goes up by exactly 1 once every (`attack_div` + 1) clocks.
- R3: The rising step that brings the level to 255 also sets `falling` to 1. The next step goes to 254, so the values run ...254, 255, 254... and never wrap to 0.
- R4: While falling and not frozen, the level goes down by exactly 1 once every (`decay_div` + 1) clocks.
- R5: The falling step that brings the level to 0 also clears `falling` to 0. The next step goes to 1, so the values run ...1, 0, 1... and never wrap to 255.
- R6: An accepted button press toggles `frozen`. While `frozen` is 1, neither the level nor `falling` changes.
- R7: A press while frozen clears `frozen`, and counting carries on from the held level in the held direction.
- R8: A high pulse on `btn_raw` that lasts fewer than DEBOUNCE_CYCLES clocks after synchronization is ignored: `frozen` keeps its value.
- R9: Only the debounced low-to-high transition of the button toggles `frozen`. A debounced release leaves it unchanged.
- R10: The active rate generator's phase restarts whenever a freeze ends or the direction flips. The first step afterwards comes (divisor + 1) clocks later. A divisor change takes effect on the running phase, and a phase already at or beyond the new divisor steps at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| attack_div | input | 16 | Rising-rate divisor; a step is taken every attack_div+1 clocks |
| decay_div | input | 16 | Falling-rate divisor; a step is taken every decay_div+1 clocks |
| btn_raw | input | 1 | Asynchronous, bouncy pushbutton level, active high |
| env_out | output | 8 | Envelope level code for the DAC |
| falling | output | 1 | Direction flag: 0 rising, 1 falling |
| frozen | output | 1 | Freeze flag: 1 while the ramp is held |

## Verification
Two events can land on the same edge: the debouncer can accept a press in the same cycle that a rate generator issues a step, or a direction flip at 0 or 255. The defined outcome is that the step, including any flip, completes on that edge, and the freeze applies from the next cycle on. The bench provokes this by using zero and very small divisors, so that a step is due on nearly every clock, while pressing at random times. A cycle-accurate bench model reads the `frozen` port as it stood before each edge and predicts the level and direction one edge at a time. Any disagreement about which of the two events won shows up as a mismatch in the very next cycle.

// File: rtl/env_ramp_pkg.sv
package env_ramp_pkg;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } ramp_dir_e;

    localparam int NUM_RATES = 2;

endpackage

// File: rtl/env_rate_tick.sv
module env_rate_tick #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] divisor,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] phase;
    } tick_state_t;

    tick_state_t st_d, st_q;

    // Phase is held at zero while idle, so a fresh run always waits divisor+1 clocks.
    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!run) begin
            st_d.phase = '0;
        end else if (st_q.phase >= divisor) begin
            tick       = 1'b1;
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/env_debounce.sv
module env_debounce #(
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic press
);

    localparam int RUN_W = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STABLE_CYCLES - 1);

    typedef struct packed {
        logic             sync1;
        logic             sync2;
        logic             level;
        logic [RUN_W-1:0] run_len;
    } deb_state_t;

    deb_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        press      = 1'b0;
        st_d.sync1 = raw;
        st_d.sync2 = st_q.sync1;
        if (st_q.sync2 == st_q.level) begin
            st_d.run_len = '0;
        end else if (st_q.run_len == RUN_LAST) begin
            // Input has disagreed with the accepted level long enough: accept it.
            st_d.level   = st_q.sync2;
            st_d.run_len = '0;
            press        = st_q.sync2;
        end else begin
            st_d.run_len = st_q.run_len + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/env_ramp_core.sv
module env_ramp_core
    import env_ramp_pkg::*;
#(
    parameter int LEVEL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic               toggle_hold,
    output logic [LEVEL_W-1:0] level,
    output ramp_dir_e          dir,
    output logic               hold
);

    localparam logic [LEVEL_W-1:0] LVL_TOP  = {LEVEL_W{1'b1}};
    localparam logic [LEVEL_W-1:0] LVL_NEAR = LVL_TOP - 1'b1;
    localparam logic [LEVEL_W-1:0] LVL_ONE  = LEVEL_W'(1);

    typedef struct packed {
        logic [LEVEL_W-1:0] level;
        ramp_dir_e          dir;
        logic               hold;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (toggle_hold) begin
            st_d.hold = !st_q.hold;
        end
        // A step pending on the edge that accepts a press still completes.
        if (step && !st_q.hold) begin
            if (st_q.dir == DIR_RISE) begin
                if (st_q.level != LVL_TOP) begin
                    st_d.level = st_q.level + 1'b1;
                end
                if (st_q.level >= LVL_NEAR) begin
                    st_d.dir = DIR_FALL;
                end
            end else begin
                if (st_q.level != '0) begin
                    st_d.level = st_q.level - 1'b1;
                end
                if (st_q.level <= LVL_ONE) begin
                    st_d.dir = DIR_RISE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.level <= '0;
            st_q.dir   <= DIR_RISE;
            st_q.hold  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
    assign dir   = st_q.dir;
    assign hold  = st_q.hold;

endmodule

// File: rtl/envelope_ramp_gen.sv
module envelope_ramp_gen
    import env_ramp_pkg::*;
#(
    parameter int LEVEL_W         = 8,
    parameter int RATE_W          = 16,
    parameter int DEBOUNCE_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATE_W-1:0]  attack_div,
    input  logic [RATE_W-1:0]  decay_div,
    input  logic               btn_raw,
    output logic [LEVEL_W-1:0] env_out,
    output logic               falling,
    output logic               frozen
);

    logic                  btn_press;
    logic                  step;
    logic [NUM_RATES-1:0]  ticks;
    logic [RATE_W-1:0]     rate_div [NUM_RATES];
    ramp_dir_e             core_dir;
    logic                  core_hold;

    assign rate_div[0] = attack_div;
    assign rate_div[1] = decay_div;

    env_debounce #(
        .STABLE_CYCLES(DEBOUNCE_CYCLES)
    ) u_debounce (
        .clk   (clk),
        .rst   (rst),
        .raw   (btn_raw),
        .press (btn_press)
    );

    // One rate generator per direction; only the one matching the direction runs.
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        logic run_g;
        assign run_g = !core_hold && (logic'(core_dir) == 1'(g));
        env_rate_tick #(
            .CNT_W(RATE_W)
        ) u_tick (
            .clk     (clk),
            .rst     (rst),
            .run     (run_g),
            .divisor (rate_div[g]),
            .tick    (ticks[g])
        );
    end

    assign step = |ticks;

    env_ramp_core #(
        .LEVEL_W(LEVEL_W)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .step        (step),
        .toggle_hold (btn_press),
        .level       (env_out),
        .dir         (core_dir),
        .hold        (core_hold)
    );

    assign falling = (core_dir == DIR_FALL);
    assign frozen  = core_hold;

endmodule

// File: rtl/env_ramp_checker.sv
module env_ramp_checker #(
    parameter int LEVEL_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [LEVEL_W-1:0] env_out,
    input logic               falling,
    input logic               frozen,
    input logic               press
);

    localparam logic [LEVEL_W-1:0] LVL_TOP = {LEVEL_W{1'b1}};

    // R3: the top value is only ever seen while falling
    a_r3_top_means_falling: assert property (@(posedge clk) disable iff (rst)
        (env_out == LVL_TOP) |-> falling);

    // R5: zero is only ever seen while rising
    a_r5_zero_means_rising: assert property (@(posedge clk) disable iff (rst)
        (env_out == '0) |-> !falling);

    // R2 / R4: level moves by at most one per clock, no wraparound jump
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (env_out == $past(env_out)
               || env_out == LEVEL_W'($past(env_out) + 1'b1)
               || env_out == LEVEL_W'($past(env_out) - 1'b1)));

    // R4: the level rises only when the previous direction was rising
    a_r4_direction_respected: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (env_out <= $past(env_out) || !$past(falling)));

    // R6: frozen state holds level and direction
    a_r6_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        frozen |=> ($stable(env_out) && $stable(falling)));

    // R9: freeze flag changes exactly when a debounced press is accepted
    a_r9_toggle_only_on_press: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((frozen != $past(frozen)) == $past(press)));

endmodule

bind envelope_ramp_gen env_ramp_checker #(
    .LEVEL_W(LEVEL_W)
) u_env_ramp_checker (
    .clk     (clk),
    .rst     (rst),
    .env_out (env_out),
    .falling (falling),
    .frozen  (frozen),
    .press   (btn_press)
);

// File: tb/tb_envelope_ramp_gen.sv
module tb_envelope_ramp_gen;

    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 16;
    localparam int MAX_CYC    = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] attack_div = '0;
    logic [15:0] decay_div  = '0;
    logic        btn_raw    = 1'b0;
    logic [7:0]  env_out;
    logic        falling;
    logic        frozen;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    // reference model state
    int m_lvl = 0;
    bit m_fall = 1'b0;
    int m_ph = 0;

    envelope_ramp_gen #(
        .LEVEL_W(8), .RATE_W(16), .DEBOUNCE_CYCLES(DEB)
    ) dut (
        .clk(clk), .rst(rst), .attack_div(attack_div), .decay_div(decay_div),
        .btn_raw(btn_raw), .env_out(env_out), .falling(falling), .frozen(frozen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int rate_now(input bit fall);
        return fall ? int'(decay_div) : int'(attack_div);
    endfunction

    // Lock-step model: compare after each edge, then predict the next edge.
    always @(negedge clk) begin
        if (rst) begin
            m_lvl = 0; m_fall = 1'b0; m_ph = 0;
        end else begin
            chk(m_fall ? "R4/R10 level" : "R2/R10 level", int'(env_out), m_lvl);
            chk("R3/R5 direction", int'(falling), int'(m_fall));
            if (frozen) begin
                m_ph = 0;
            end else if (m_ph >= rate_now(m_fall)) begin
                m_ph = 0;
                if (!m_fall) begin
                    m_lvl++;
                    if (m_lvl == 255) m_fall = 1'b1;
                end else begin
                    m_lvl--;
                    if (m_lvl == 0) m_fall = 1'b0;
                end
            end else begin
                m_ph++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > MAX_CYC) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_rates(input int a, input int d);
        @(posedge clk); #1;
        attack_div = 16'(a);
        decay_div  = 16'(d);
    endtask

    task automatic wait_flag(input bit want_fall, input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (falling == want_fall) break;
        end
    endtask

    task automatic press(input int hi, input int lo);
        @(posedge clk); #1;
        btn_raw = 1'b1;
        negs(hi);
        btn_raw = 1'b0;
        negs(lo);
    endtask

    initial begin
        int held;
        bit was;
        void'($urandom(32'h5EED));
        negs(3);
        chk("R1 reset level", int'(env_out), 0);
        chk("R1 reset falling", int'(falling), 0);
        chk("R1 reset frozen", int'(frozen), 0);
        @(posedge clk); #1 rst = 1'b0;

        // R2/R3/R4/R5: fast sweep through both extremes
        wait_flag(1'b1, 2000);
        chk("R3 top reached", int'(env_out), 255);
        negs(1);
        chk("R3 no wrap after top", int'(env_out), 254);
        wait_flag(1'b0, 2000);
        chk("R5 bottom reached", int'(env_out), 0);
        negs(1);
        chk("R5 no wrap after bottom", int'(env_out), 1);

        // slower distinct rates, lockstep checks the R2/R4 periods
        set_rates(3, 1);
        wait_flag(1'b1, 5000);
        wait_flag(1'b0, 5000);

        // R6/R7/R9 freeze and resume
        set_rates(0, 0);
        negs(37);
        @(posedge clk); #1 btn_raw = 1'b1;
        negs(DEB + 6);
        chk("R6 frozen after press", int'(frozen), 1);
        held = int'(env_out);
        was = falling;
        negs(40);
        chk("R6 level held", int'(env_out), held);
        chk("R6 direction held", int'(falling), int'(was));
        btn_raw = 1'b0;
        negs(DEB + 6);
        chk("R9 release keeps frozen", int'(frozen), 1);
        chk("R6 level held after release", int'(env_out), held);
        @(posedge clk); #1 btn_raw = 1'b1;
        for (int i = 0; i < DEB + 10; i++) begin
            @(negedge clk);
            if (!frozen) break;
        end
        chk("R7 unfrozen", int'(frozen), 0);
        chk("R7 resumes from held level", int'(env_out), held);
        negs(3);
        chk("R7 counting again", int'(env_out != held[7:0]), 1);
        btn_raw = 1'b0;
        negs(DEB + 6);

        // R8 glitch rejection
        was = frozen;
        press(DEB / 2, DEB + 6);
        chk("R8 short pulse ignored", int'(frozen), int'(was));
        press(DEB - 3, DEB + 6);
        chk("R8 near-window pulse ignored", int'(frozen), int'(was));

        // random mix: presses racing steps, divisor changes
        for (int k = 0; k < 60; k++) begin
            set_rates($urandom_range(0, 4), $urandom_range(0, 4));
            was = frozen;
            if ($urandom_range(0, 2) == 0) begin
                press($urandom_range(1, DEB - 3), DEB + 4);
                chk("R8 random glitch ignored", int'(frozen), int'(was));
            end else begin
                press($urandom_range(DEB + 3, DEB + 20), DEB + 4);
                chk("R6 random press toggles", int'(frozen), int'(!was));
            end
            negs($urandom_range(20, 400));
        end

        // leave unfrozen and run to both ends once more
        if (frozen) press(DEB + 4, DEB + 4);
        set_rates(0, 2);
        wait_flag(1'b1, 4000);
        chk("R3 top at end", int'(env_out), 255);
        wait_flag(1'b0, 4000);
        chk("R5 bottom at end", int'(env_out), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule